// File: doc/BRIEF.md
# Block Bitmap Allocator

This block hands out regions of a 16384-byte shared buffer. The buffer is cut into 64 blocks of 256 bytes. Occupancy is held in a bitmap of two 32-bit words. A requester asks for a byte count, and the block returns a byte offset into the buffer. When no region fits, it returns an out-of-memory flag instead. A requester can also hand a region back by giving its offset and size, and those blocks are then released.

An allocation rounds its size up to whole blocks. Candidate start positions are spaced and aligned on the smallest power of two of blocks that holds the request. Only the blocks the request actually needs are marked as used. Candidates are tried lowest first, all of word 0 before word 1, and a region never straddles a map word. The scan can test several candidates per clock (parameter `LANES`), which trades comparator area against search latency.

Commands use a valid/ready handshake and are handled one at a time. Every command ends with a one-cycle done pulse that carries an offset and an out-of-memory flag. A synchronous clear input empties the whole map at any time.

Top module: `blk_alloc`

## Requirements
- R1: An allocation claims ceil(size/256) blocks and marks exactly that many map bits, leaving the rest of its aligned slot free for later requests.
- R2: Candidate start blocks are multiples of the smallest power of two (1, 2, 4, 8, 16, 32) that is not below the block count of the request.
- R3: The winning candidate is the lowest free one, scanning map word 0 (blocks 0..31) before map word 1 (blocks 32..63). A region never covers blocks from both words.
- R4: When no candidate fits, the response has `rsp_oom_o`=1 and `rsp_offset_o`=16384.
- R5: A zero-byte allocation fails with `rsp_oom_o`=1 and offset 16384.
- R6: An allocation of more than 8192 bytes (over 32 blocks) fails with `rsp_oom_o`=1 and offset 16384.
- R7: A successful allocation reports `rsp_oom_o`=0 and offset = start block × 256.
- R8: A free (`cmd_free_i`=1) clears ceil(size/256) bits, starting at block floor(offset/256). Its response has `rsp_oom_o`=0 and echoes the offset given.
- R9: A free clears only bits inside the map word that holds its start block; bits that would fall past bit 31 of that word stay set. A free whose offset is 16384 or above changes nothing.
- R10: A cycle with `clear_i`=1 empties the map, abandons any search without a done pulse, and drops `cmd_ready_o`.
- R11: `cmd_ready_o` is 1 only while idle, and `busy_o` is 1 during a search. A free gives its done pulse in the cycle after acceptance. An allocation's first group of `LANES` candidates is judged on the next edge, so on an empty map its done pulse appears two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous map clear and search abort |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| cmd_free_i | input | 1 | 0 = allocate, 1 = free |
| cmd_size_i | input | 16 | Request size in bytes |
| cmd_offset_i | input | 15 | Byte offset of the region to free |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_oom_o | output | 1 | Allocation failed |
| rsp_offset_o | output | 15 | Allocated offset, sentinel 16384, or echoed free offset |
| busy_o | output | 1 | Search in progress |

## Verification
The properties assume that `cmd_valid_i` only counts in a cycle where `cmd_ready_o` is high, and that command fields are sampled in that cycle alone. The bench raises valid for exactly one accepted cycle per command and waits for the done pulse before sending the next. Frees in the stimulus name ranges that were allocated earlier. The only exceptions are deliberate boundary frees: one past the end of the memory, one with an unaligned offset, and one that would run past a word end. Double-free checking is not part of this block. `clear_i` is pulsed only between commands or in the middle of a long search.

// File: rtl/blk_alloc_pkg.sv
package blk_alloc_pkg;
  localparam int unsigned MEM_BYTES_DEF   = 16384;
  localparam int unsigned BLOCK_BYTES_DEF = 256;
  localparam int unsigned WORD_BITS_DEF   = 32;
  localparam int unsigned LANES_DEF       = 4;

  typedef enum logic {OP_ALLOC = 1'b0, OP_FREE = 1'b1} alloc_op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} alloc_st_e;

  // n low ones, saturating at 64
  function automatic logic [63:0] low_ones(input logic [31:0] n);
    if (n >= 32'd64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/blk_alloc_size_dec.sv
module blk_alloc_size_dec #(
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned WORD_BITS   = 32,
  localparam int unsigned BLK_LOG2   = $clog2(BLOCK_BYTES),
  localparam int unsigned WORD_LOG2  = $clog2(WORD_BITS),
  localparam int unsigned CNT_W      = WORD_LOG2 + 1,
  localparam int unsigned SL_W       = $clog2(WORD_LOG2 + 1)
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [CNT_W-1:0]  blocks_o,
  output logic [SL_W-1:0]   stride_log2_o,
  output logic              zero_o,
  output logic              too_big_o
);
  logic [SIZE_W:0] padded;
  logic [SIZE_W:0] full_blk;

  assign padded    = {1'b0, size_i} + (SIZE_W+1)'(BLOCK_BYTES - 1);
  assign full_blk  = padded >> BLK_LOG2;
  assign zero_o    = (size_i == '0);
  assign too_big_o = full_blk > (SIZE_W+1)'(WORD_BITS);
  // clamped count, used as-is by free
  assign blocks_o  = too_big_o ? CNT_W'(WORD_BITS) : full_blk[CNT_W-1:0];

  always_comb begin
    stride_log2_o = SL_W'(WORD_LOG2);
    for (int k = WORD_LOG2; k >= 0; k--) begin
      if (((CNT_W+1)'(1) << k) >= (CNT_W+1)'(blocks_o)) stride_log2_o = SL_W'(k);
    end
  end
endmodule

// File: rtl/blk_alloc_scan.sv
module blk_alloc_scan #(
  parameter int unsigned WORDS     = 2,
  parameter int unsigned WORD_BITS = 32,
  parameter int unsigned LANES     = 4,
  localparam int unsigned NBLK      = WORDS * WORD_BITS,
  localparam int unsigned IDX_W     = $clog2(NBLK),
  localparam int unsigned CAND_W    = IDX_W + 1,
  localparam int unsigned WORD_LOG2 = $clog2(WORD_BITS),
  localparam int unsigned CNT_W     = WORD_LOG2 + 1,
  localparam int unsigned SL_W      = $clog2(WORD_LOG2 + 1)
) (
  input  logic [NBLK-1:0]   map_i,
  input  logic [CAND_W-1:0] base_i,
  input  logic [CNT_W-1:0]  blocks_i,
  input  logic [SL_W-1:0]   stride_log2_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              exhausted_o
);
  import blk_alloc_pkg::*;

  logic [CAND_W-1:0]    total;
  logic [WORD_BITS-1:0] run;
  logic [LANES-1:0]     lane_hit;
  logic [IDX_W-1:0]     lane_idx [LANES];

  assign total = CAND_W'(NBLK) >> stride_log2_i;
  assign run   = WORD_BITS'(low_ones(32'(blocks_i)));
  assign exhausted_o = ((CAND_W+1)'(base_i) + (CAND_W+1)'(LANES)) >= (CAND_W+1)'(total);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CAND_W-1:0] cand;
    logic [NBLK-1:0]   shifted;
    assign cand         = base_i + CAND_W'(l);
    assign lane_idx[l]  = IDX_W'(cand << stride_log2_i);
    // aligned slots never cross a word, so a flat shift is exact
    assign shifted      = map_i >> lane_idx[l];
    assign lane_hit[l]  = (cand < total) && ((shifted[WORD_BITS-1:0] & run) == '0);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (lane_hit[l]) begin
        hit_o     = 1'b1;
        hit_idx_o = lane_idx[l];
      end
    end
  end
endmodule

// File: rtl/blk_alloc.sv
module blk_alloc #(
  parameter int unsigned MEM_BYTES   = blk_alloc_pkg::MEM_BYTES_DEF,
  parameter int unsigned BLOCK_BYTES = blk_alloc_pkg::BLOCK_BYTES_DEF,
  parameter int unsigned WORD_BITS   = blk_alloc_pkg::WORD_BITS_DEF,
  parameter int unsigned LANES       = blk_alloc_pkg::LANES_DEF,
  parameter int unsigned SIZE_W      = 16,
  localparam int unsigned OFF_W      = $clog2(MEM_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_free_i,
  input  logic [SIZE_W-1:0] cmd_size_i,
  input  logic [OFF_W-1:0]  cmd_offset_i,
  output logic              rsp_done_o,
  output logic              rsp_oom_o,
  output logic [OFF_W-1:0]  rsp_offset_o,
  output logic              busy_o
);
  import blk_alloc_pkg::*;

  localparam int unsigned NBLK      = MEM_BYTES / BLOCK_BYTES;
  localparam int unsigned WORDS     = NBLK / WORD_BITS;
  localparam int unsigned IDX_W     = $clog2(NBLK);
  localparam int unsigned CAND_W    = IDX_W + 1;
  localparam int unsigned BLK_LOG2  = $clog2(BLOCK_BYTES);
  localparam int unsigned WORD_LOG2 = $clog2(WORD_BITS);
  localparam int unsigned CNT_W     = WORD_LOG2 + 1;
  localparam int unsigned SL_W      = $clog2(WORD_LOG2 + 1);
  localparam int unsigned FIDX_W    = OFF_W - BLK_LOG2;

  alloc_st_e         state_q;
  alloc_op_e         op;
  logic [NBLK-1:0]   map_q, map_d;
  logic [CNT_W-1:0]  blocks_q;
  logic [SL_W-1:0]   sl_q;
  logic              bad_q;
  logic [CAND_W-1:0] base_q;
  logic              done_q, oom_q;
  logic [OFF_W-1:0]  off_q;
  logic              accept;

  logic [CNT_W-1:0]  dec_blocks;
  logic [SL_W-1:0]   dec_sl;
  logic              dec_zero, dec_big;

  logic              hit, exhausted;
  logic [IDX_W-1:0]  hit_idx;
  logic [NBLK-1:0]   set_mask;

  assign op          = alloc_op_e'(cmd_free_i);
  assign cmd_ready_o = (state_q == ST_IDLE) && !clear_i;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign busy_o      = (state_q == ST_SCAN);
  assign rsp_done_o  = done_q;
  assign rsp_oom_o   = oom_q;
  assign rsp_offset_o = off_q;

  blk_alloc_size_dec #(
    .SIZE_W(SIZE_W), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BITS(WORD_BITS)
  ) i_size_dec (
    .size_i(cmd_size_i), .blocks_o(dec_blocks), .stride_log2_o(dec_sl),
    .zero_o(dec_zero), .too_big_o(dec_big)
  );

  blk_alloc_scan #(
    .WORDS(WORDS), .WORD_BITS(WORD_BITS), .LANES(LANES)
  ) i_scan (
    .map_i(map_q), .base_i(base_q), .blocks_i(blocks_q), .stride_log2_i(sl_q),
    .hit_o(hit), .hit_idx_o(hit_idx), .exhausted_o(exhausted)
  );

  // free: per-word clear mask, confined to the word holding the start block
  logic [FIDX_W-1:0]    free_idx;
  logic                 free_in_range;
  logic [WORD_BITS-1:0] free_run;
  logic [WORD_BITS-1:0] free_word_mask;
  logic [NBLK-1:0]      clr_all;

  assign free_idx       = FIDX_W'(cmd_offset_i >> BLK_LOG2);
  assign free_in_range  = free_idx < FIDX_W'(NBLK);
  assign free_run       = WORD_BITS'(low_ones(32'(dec_blocks)));
  assign free_word_mask = free_run << free_idx[WORD_LOG2-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_free_word
    assign clr_all[w*WORD_BITS +: WORD_BITS] =
      (free_in_range && (free_idx >> WORD_LOG2) == FIDX_W'(w)) ? free_word_mask : '0;
  end

  assign set_mask = NBLK'(WORD_BITS'(low_ones(32'(blocks_q)))) << hit_idx;

  always_comb begin
    map_d = map_q;
    if (accept && op == OP_FREE) map_d = map_d & ~clr_all;
    if (state_q == ST_SCAN && !bad_q && hit) map_d = map_d | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      map_q    <= '0;
      blocks_q <= '0;
      sl_q     <= '0;
      bad_q    <= 1'b0;
      base_q   <= '0;
      done_q   <= 1'b0;
      oom_q    <= 1'b0;
      off_q    <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      done_q  <= 1'b0;
      oom_q   <= 1'b0;
      off_q   <= '0;
    end else begin
      map_q  <= map_d;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (op == OP_FREE) begin
              done_q <= 1'b1;
              oom_q  <= 1'b0;
              off_q  <= cmd_offset_i;
            end else begin
              state_q  <= ST_SCAN;
              blocks_q <= dec_blocks;
              sl_q     <= dec_sl;
              bad_q    <= dec_zero || dec_big;
              base_q   <= '0;
            end
          end
        end
        ST_SCAN: begin
          if (bad_q || (!hit && exhausted)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            oom_q   <= 1'b1;
            off_q   <= OFF_W'(MEM_BYTES);
          end else if (hit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            oom_q   <= 1'b0;
            off_q   <= OFF_W'(hit_idx) << BLK_LOG2;
          end else begin
            base_q <= base_q + CAND_W'(LANES);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_alloc_chk.sv
module blk_alloc_chk #(
  parameter int unsigned MEM_BYTES   = 16384,
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned WORD_BITS   = 32,
  parameter int unsigned SIZE_W      = 16,
  localparam int unsigned OFF_W      = $clog2(MEM_BYTES) + 1,
  localparam int unsigned BLK_LOG2   = $clog2(BLOCK_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              cmd_free_i,
  input logic [SIZE_W-1:0] cmd_size_i,
  input logic              rsp_done_o,
  input logic              rsp_oom_o,
  input logic [OFF_W-1:0]  rsp_offset_o,
  input logic              busy_o
);
  logic acc_alloc, acc_free;
  assign acc_alloc = cmd_valid_i && cmd_ready_o && !cmd_free_i && !clear_i;
  assign acc_free  = cmd_valid_i && cmd_ready_o && cmd_free_i && !clear_i;

  p_fail_sentinel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && rsp_oom_o) |-> rsp_offset_o == OFF_W'(MEM_BYTES));

  p_ok_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_oom_o && !$past(cmd_free_i)) |->
      (rsp_offset_o < OFF_W'(MEM_BYTES)) && (rsp_offset_o[BLK_LOG2-1:0] == '0));

  p_zero_fails_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_alloc && cmd_size_i == '0) |=> ##1 (clear_i || (rsp_done_o && rsp_oom_o)));

  p_oversize_fails_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_alloc && ({1'b0, cmd_size_i} > (SIZE_W+1)'(WORD_BITS * BLOCK_BYTES)))
      |=> ##1 (clear_i || (rsp_done_o && rsp_oom_o)));

  p_free_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_free |=> (clear_i || (rsp_done_o && !rsp_oom_o)));

  p_busy_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o);

  p_clear_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!rsp_done_o && !busy_o));
endmodule

bind blk_alloc blk_alloc_chk #(
  .MEM_BYTES(MEM_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BITS(WORD_BITS), .SIZE_W(SIZE_W)
) i_blk_alloc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o), .cmd_free_i(cmd_free_i), .cmd_size_i(cmd_size_i),
  .rsp_done_o(rsp_done_o), .rsp_oom_o(rsp_oom_o), .rsp_offset_o(rsp_offset_o),
  .busy_o(busy_o)
);

// File: tb/test_blk_alloc.sv
module test_blk_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_free_i = 1'b0;
  logic [15:0] cmd_size_i = '0;
  logic [14:0] cmd_offset_i = '0;
  logic        rsp_done_o, rsp_oom_o, busy_o;
  logic [14:0] rsp_offset_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_alloc i_blk_alloc (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o), .cmd_free_i(cmd_free_i), .cmd_size_i(cmd_size_i),
    .cmd_offset_i(cmd_offset_i), .rsp_done_o(rsp_done_o), .rsp_oom_o(rsp_oom_o),
    .rsp_offset_o(rsp_offset_o), .busy_o(busy_o)
  );

  // {free, size, offset, exp_offset, exp_oom, tag}
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 16'd1,    15'd0,    15'd0,     1'b0, 4'd7},
    {1'b0, 16'd300,  15'd0,    15'd512,   1'b0, 4'd1},
    {1'b0, 16'd256,  15'd0,    15'd256,   1'b0, 4'd1},
    {1'b0, 16'd700,  15'd0,    15'd1024,  1'b0, 4'd2},
    {1'b0, 16'd200,  15'd0,    15'd1792,  1'b0, 4'd3},
    {1'b0, 16'd4096, 15'd0,    15'd4096,  1'b0, 4'd2},
    {1'b0, 16'd8192, 15'd0,    15'd8192,  1'b0, 4'd3},
    {1'b0, 16'd1,    15'd0,    15'd2048,  1'b0, 4'd3},
    {1'b0, 16'd8193, 15'd0,    15'd16384, 1'b1, 4'd6},
    {1'b0, 16'd0,    15'd0,    15'd16384, 1'b1, 4'd5},
    {1'b1, 16'd700,  15'd1024, 15'd1024,  1'b0, 4'd8},
    {1'b0, 16'd512,  15'd0,    15'd1024,  1'b0, 4'd2},
    {1'b0, 16'd256,  15'd0,    15'd1536,  1'b0, 4'd8},
    {1'b1, 16'd8192, 15'd8192, 15'd8192,  1'b0, 4'd8},
    {1'b0, 16'd5000, 15'd0,    15'd8192,  1'b0, 4'd3},
    {1'b0, 16'd4096, 15'd0,    15'd16384, 1'b1, 4'd4},
    {1'b0, 16'd2048, 15'd0,    15'd14336, 1'b0, 4'd3}
  };

  function automatic string tag_s(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic fr, input logic [15:0] sz, input logic [14:0] off,
                        output int g_off, output int g_oom, output int lat);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_free_i = fr; cmd_size_i = sz; cmd_offset_i = off;
    @(posedge clk);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    lat = 0;
    while (!rsp_done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    g_off = int'(rsp_offset_o);
    g_oom = int'(rsp_oom_o);
  endtask

  task automatic expect_cmd(input string req, input logic fr, input logic [15:0] sz,
                            input logic [14:0] off, input int e_off, input int e_oom);
    int g_off, g_oom, lat;
    do_cmd(fr, sz, off, g_off, g_oom, lat);
    chk(req, "timeout", int'(lat >= 200), 0);
    chk(req, "offset", g_off, e_off);
    chk(req, "oom", g_oom, e_oom);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int g_off, g_oom, lat;
    repeat (3) @(negedge clk);
    // reset state, R11
    chk("R11", "reset ready", int'(cmd_ready_o), 1);
    chk("R11", "reset busy", int'(busy_o), 0);
    chk("R11", "reset done", int'(rsp_done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      do_cmd(v[51], v[50:35], v[34:20], g_off, g_oom, lat);
      chk(tag_s(int'(v[3:0])), "offset", g_off, int'(v[19:5]));
      chk(tag_s(int'(v[3:0])), "oom", g_oom, int'(v[4]));
      // latency: empty-map alloc judged on first group (R11), free next cycle (R11)
      if (i == 0)  chk("R11", "alloc latency", lat, 1);
      if (i == 10) chk("R11", "free latency", lat, 0);
    end

    // R10: clear empties map, ready low while clear is high
    @(negedge clk); clear_i = 1'b1;
    #1 chk("R10", "ready during clear", int'(cmd_ready_o), 0);
    @(negedge clk); clear_i = 1'b0;
    expect_cmd("R10", 1'b0, 16'd8192, 15'd0, 0, 0);
    expect_cmd("R3", 1'b0, 16'd8192, 15'd0, 8192, 0);
    expect_cmd("R4", 1'b0, 16'd1, 15'd0, 16384, 1);
    // R9: free of 4 blocks from block 31 only touches bit 31 of word 0
    expect_cmd("R9", 1'b1, 16'd1024, 15'd7936, 7936, 0);
    expect_cmd("R9", 1'b0, 16'd256, 15'd0, 7936, 0);
    expect_cmd("R9", 1'b0, 16'd256, 15'd0, 16384, 1);
    // R9: free beyond memory changes nothing
    expect_cmd("R9", 1'b1, 16'd256, 15'd16384, 16384, 0);
    expect_cmd("R9", 1'b0, 16'd256, 15'd0, 16384, 1);
    // R8: unaligned offset floors to its block
    expect_cmd("R8", 1'b1, 16'd256, 15'd300, 300, 0);
    expect_cmd("R8", 1'b0, 16'd256, 15'd0, 256, 0);

    // R10/R11: abort a long search on a full map
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_free_i = 1'b0; cmd_size_i = 16'd256;
    @(posedge clk);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk("R11", "busy in search", int'(busy_o), 1);
    chk("R11", "ready in search", int'(cmd_ready_o), 0);
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      seen += int'(rsp_done_o);
      clear_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0;
      for (int k = 0; k < 20; k++) begin
        seen += int'(rsp_done_o);
        @(negedge clk);
      end
      chk("R10", "done after abort", seen, 0);
      chk("R10", "busy after abort", int'(busy_o), 0);
    end
    expect_cmd("R10", 1'b0, 16'd8192, 15'd0, 0, 0);
    pulse_clear();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule